// File: doc/BRIEF.md
# Chunk Mailbox Filter for Object Intersection Requests

This block sits between a kd-tree traversal stage and an object intersection stage. A chunk of four rays runs through the tree together, and one object often reaches into several leaf cells. Without a filter, the intersection stage would test that object once for each cell it occupies. The filter holds a small cache of object identifiers shared by the whole chunk. When a leaf sends an identifier that the cache already holds, the block accepts the request and discards it. When the identifier is new, the block writes it into the cache and passes the request on to intersection.

The cache has four entries by default. A new identifier replaces entries in round-robin order, and the cache is emptied when the chunk starts a new trace. Both sides of the block use valid/ready handshakes. The hit or miss decision is made in the cycle the request is accepted. Two running counters report how many requests were dropped and how many were forwarded.

Control is a two-state machine:
- In **LOOKUP** the block accepts requests. A hit stays in LOOKUP (transition *drop*). A miss moves to FORWARD (transition *issue*).
- In **FORWARD** the block presents the captured request downstream. It returns to LOOKUP when the receiver takes it (transition *retire*) and otherwise stays (transition *stall*).

Top module: `mailbox_filter`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, both counters are 0 and the cache is empty, so the first request of any identifier is a miss.
- R2: A request whose identifier is not in the cache is forwarded with the same identifier and lane mask. out_valid rises in the cycle after acceptance and holds, with stable payload, until out_ready is seen high.
- R3: A request whose identifier is in the cache is accepted and dropped. No out_valid results from it.
- R4: The cache holds ENTRIES (4) identifiers. Each miss writes the next slot in round-robin order starting at slot 0, so the fifth distinct identifier after a clear evicts the first one and leaves the other three present.
- R5: A trace_start pulse empties every entry and returns the replacement position to slot 0. in_ready is 0 in that cycle, so a request offered at the same time is not taken.
- R6: in_ready is 0 whenever out_valid is 1, so only one forwarded request is outstanding at a time.
- R7: hit_count rises by one for each dropped request and miss_count rises by one for each forwarded request. Neither counter changes in a cycle without an accepted request. Both wrap at 2^CNT_W.
- R8: A trace_start that arrives while a forward is pending leaves out_valid, out_obj and out_lanes unchanged until out_ready takes the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_start | input | 1 | Chunk begins a new trace; clears the cache |
| in_valid | input | 1 | Traversal offers an object request |
| in_ready | output | 1 | Filter can accept a request this cycle |
| in_obj | input | ID_W | Object identifier from the leaf |
| in_lanes | input | LANES | Rays of the chunk that want this object |
| out_valid | output | 1 | Forwarded request present for intersection |
| out_ready | input | 1 | Intersection takes the request |
| out_obj | output | ID_W | Forwarded object identifier |
| out_lanes | output | LANES | Forwarded lane mask |
| hit_count | output | CNT_W | Requests dropped as redundant |
| miss_count | output | CNT_W | Requests forwarded |

## Verification
Each fault in the cache shows at the ports in a different way:
- A stale or lost cache entry changes which later requests are forwarded. The forward stream differs from the model as soon as the affected identifier comes back, usually one or two requests later.
- A wrong replacement position only shows once the cache wraps, at the fifth distinct identifier after a clear. The eviction tests therefore walk past that point and then return to the evicted and the kept identifiers.
- A controller stuck in FORWARD, or leaving it too early, shows within one cycle: either in_ready stays low or the payload changes while the receiver stalls.

The bench compares every forwarded item with a scoreboard built from a reference cache and checks both counters at the end of each phase.

// File: rtl/mbf_pkg.sv
package mbf_pkg;
    typedef enum logic [0:0] {
        ST_LOOKUP  = 1'b0,
        ST_FORWARD = 1'b1
    } mbf_state_e;
endpackage

// File: rtl/mbf_tag_store.sv
module mbf_tag_store #(
    parameter int ENTRIES = 4,
    parameter int ID_W    = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [ID_W-1:0] look_id,
    output logic            hit,
    input  logic            ins_en,
    input  logic [ID_W-1:0] ins_id
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    logic [ID_W-1:0]    tag_q [ENTRIES];
    logic [ENTRIES-1:0] vld_q;
    logic [ENTRIES-1:0] match;
    logic [PTR_W-1:0]   ptr_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign match[g] = vld_q[g] && (tag_q[g] == look_id);

        always_ff @(posedge clk) begin
            if (ins_en && !clr && (ptr_q == PTR_W'(g)))
                tag_q[g] <= ins_id;
        end

        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                vld_q[g] <= 1'b0;
            else if (ins_en && (ptr_q == PTR_W'(g)))
                vld_q[g] <= 1'b1;
        end
    end

    assign hit = |match;

    // round-robin replacement position
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            ptr_q <= '0;
        else if (ins_en)
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
endmodule

// File: rtl/mbf_ctrl.sv
module mbf_ctrl
    import mbf_pkg::*;
#(
    parameter int ID_W  = 16,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trace_start,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [ID_W-1:0]  in_obj,
    input  logic [LANES-1:0] in_lanes,
    input  logic             hit,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [ID_W-1:0]  out_obj,
    output logic [LANES-1:0] out_lanes,
    output logic             ins_en,
    output logic             clr,
    output logic             hit_ev,
    output logic             miss_ev
);
    mbf_state_e state_q, state_d;
    logic [ID_W-1:0]  obj_q;
    logic [LANES-1:0] lanes_q;
    logic             accept;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOOKUP;
        else        state_q <= state_d;
    end

    // outputs and next state
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        state_d   = state_q;
        unique case (state_q)
            ST_LOOKUP: begin
                in_ready = !trace_start;
                if (in_valid && in_ready && !hit)
                    state_d = ST_FORWARD;            // issue
            end
            ST_FORWARD: begin
                out_valid = 1'b1;
                if (out_ready)
                    state_d = ST_LOOKUP;             // retire
            end
            default: state_d = ST_LOOKUP;
        endcase
        accept  = in_valid && in_ready;
        ins_en  = accept && !hit;
        hit_ev  = accept && hit;
        miss_ev = ins_en;
        clr     = trace_start;
    end

    always_ff @(posedge clk) begin
        if (ins_en) begin
            obj_q   <= in_obj;
            lanes_q <= in_lanes;
        end
    end

    assign out_obj   = obj_q;
    assign out_lanes = lanes_q;
endmodule

// File: rtl/mbf_stats.sv
module mbf_stats #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_ev,
    input  logic             miss_ev,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_count  <= '0;
            miss_count <= '0;
        end else begin
            if (hit_ev)  hit_count  <= hit_count + 1'b1;
            if (miss_ev) miss_count <= miss_count + 1'b1;
        end
    end
endmodule

// File: rtl/mailbox_filter.sv
module mailbox_filter #(
    parameter int ENTRIES = 4,
    parameter int ID_W    = 16,
    parameter int LANES   = 4,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trace_start,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [ID_W-1:0]  in_obj,
    input  logic [LANES-1:0] in_lanes,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [ID_W-1:0]  out_obj,
    output logic [LANES-1:0] out_lanes,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);
    logic hit, ins_en, clr, hit_ev, miss_ev;

    mbf_tag_store #(.ENTRIES(ENTRIES), .ID_W(ID_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .clr(clr), .look_id(in_obj),
        .hit(hit), .ins_en(ins_en), .ins_id(in_obj)
    );

    mbf_ctrl #(.ID_W(ID_W), .LANES(LANES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .trace_start(trace_start),
        .in_valid(in_valid), .in_ready(in_ready), .in_obj(in_obj),
        .in_lanes(in_lanes), .hit(hit), .out_valid(out_valid),
        .out_ready(out_ready), .out_obj(out_obj), .out_lanes(out_lanes),
        .ins_en(ins_en), .clr(clr), .hit_ev(hit_ev), .miss_ev(miss_ev)
    );

    mbf_stats #(.CNT_W(CNT_W)) u_stats (
        .clk(clk), .rst_n(rst_n), .hit_ev(hit_ev), .miss_ev(miss_ev),
        .hit_count(hit_count), .miss_count(miss_count)
    );
endmodule

// File: rtl/mbf_checker.sv
module mbf_checker #(
    parameter int ID_W  = 16,
    parameter int LANES = 4,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trace_start,
    input logic             in_valid,
    input logic             in_ready,
    input logic [ID_W-1:0]  in_obj,
    input logic [LANES-1:0] in_lanes,
    input logic             out_valid,
    input logic             out_ready,
    input logic [ID_W-1:0]  out_obj,
    input logic [LANES-1:0] out_lanes,
    input logic [CNT_W-1:0] hit_count,
    input logic [CNT_W-1:0] miss_count
);
    // R2 and R8: a stalled forward keeps its payload
    p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_obj) && $stable(out_lanes)));

    // R6: one outstanding forward
    p_busy_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R5: clear cycle takes no request
    p_start_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trace_start |-> !in_ready);

    // R3: forward appears exactly when the miss counter moves
    p_fwd_iff_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid == (miss_count != $past(miss_count))));

    // R7: each acceptance moves exactly one counter
    p_count_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=>
            ((hit_count != $past(hit_count)) != (miss_count != $past(miss_count))));

    p_count_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> ($stable(hit_count) && $stable(miss_count)));

    // R1: reset values
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && hit_count == '0 && miss_count == '0));
endmodule

bind mailbox_filter mbf_checker #(.ID_W(ID_W), .LANES(LANES), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_mailbox_filter.sv
`timescale 1ns/1ps
module tb_mailbox_filter;
    localparam int ID_W = 16, LANES = 4, CNT_W = 16, ENTRIES = 4;

    logic clk = 0, rst_n = 0, trace_start = 0;
    logic in_valid = 0, in_ready, out_valid, out_ready;
    logic [ID_W-1:0] in_obj = '0, out_obj;
    logic [LANES-1:0] in_lanes = '0, out_lanes;
    logic [CNT_W-1:0] hit_count, miss_count;

    always #2.5 clk = ~clk;

    mailbox_filter #(.ENTRIES(ENTRIES), .ID_W(ID_W), .LANES(LANES), .CNT_W(CNT_W)) dut (.*);

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    bit hold_out = 0, stall_mode = 0;
    logic [7:0] lfsr = 8'h5A;
    logic [ID_W+LANES-1:0] exp_q[$];
    logic [ID_W-1:0] m_tag[ENTRIES];
    bit m_vld[ENTRIES];
    int m_ptr = 0;
    int exp_hits = 0, exp_miss = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit m_hit(input logic [ID_W-1:0] id);
        for (int i = 0; i < ENTRIES; i++)
            if (m_vld[i] && m_tag[i] == id) return 1;
        return 0;
    endfunction

    task automatic m_clear();
        for (int i = 0; i < ENTRIES; i++) m_vld[i] = 0;
        m_ptr = 0;
    endtask

    // driver: offers one request and pushes the expected forward
    task automatic send(input logic [ID_W-1:0] id, input logic [LANES-1:0] ln);
        @(negedge clk);
        in_valid = 1; in_obj = id; in_lanes = ln;
        while (!in_ready) @(negedge clk);
        if (m_hit(id)) exp_hits++;
        else begin
            exp_q.push_back({id, ln});
            m_tag[m_ptr] = id; m_vld[m_ptr] = 1;
            m_ptr = (m_ptr + 1) % ENTRIES;
            exp_miss++;
        end
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic drain();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !out_valid) break;
        end
    endtask

    task automatic check_counts(input string req);
        chk(hit_count == CNT_W'(exp_hits), {req, " hit_count"}, hit_count, exp_hits);
        chk(miss_count == CNT_W'(exp_miss), {req, " miss_count"}, miss_count, exp_miss);
    endtask

    // clear pulse with a request offered at the same time (R5)
    task automatic start_trace(input logic [ID_W-1:0] id);
        @(negedge clk);
        trace_start = 1; in_valid = 1; in_obj = id; in_lanes = 4'hF;
        #0.1;
        chk(in_ready == 1'b0, "R5 in_ready during trace_start", in_ready, 0);
        @(negedge clk);
        trace_start = 0; in_valid = 0;
        m_clear();
    endtask

    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = hold_out ? 1'b0 : (stall_mode ? lfsr[0] : 1'b1);
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid)
                chk(!in_ready, "R6 in_ready while forwarding", in_ready, 0);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0)
                    chk(0, "R3 unexpected forward obj", out_obj, -1);
                else begin
                    logic [ID_W+LANES-1:0] e;
                    e = exp_q.pop_front();
                    chk({out_obj, out_lanes} == e, "R2 forwarded payload", {out_obj, out_lanes}, e);
                end
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        out_ready = 1;
        m_clear();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
        chk(in_ready == 1, "R1 in_ready after reset", in_ready, 1);
        check_counts("R1");

        // R2 / R3 basic hits and misses
        send(16'd10, 4'h1);
        send(16'd10, 4'h2);
        send(16'd20, 4'h4);
        send(16'd10, 4'h8);
        send(16'd20, 4'h3);
        drain();
        chk(exp_q.size() == 0, "R3 all forwards seen", exp_q.size(), 0);
        check_counts("R3 R7");

        // R4 round-robin replacement
        start_trace(16'd10);
        check_counts("R5 no accept on clear");
        for (int i = 1; i <= 4; i++) send(16'(i), 4'h1);
        for (int i = 1; i <= 4; i++) send(16'(i), 4'h2);
        send(16'd5, 4'h4);       // evicts 1
        send(16'd2, 4'h1); send(16'd3, 4'h1); send(16'd4, 4'h1);
        send(16'd1, 4'h8);       // miss, evicts 2
        send(16'd2, 4'h8);       // miss, evicts 3
        send(16'd5, 4'h8);       // hit
        drain();
        check_counts("R4");

        // R5: previously cached id misses after clear
        start_trace(16'd5);
        send(16'd5, 4'h6);
        drain();
        check_counts("R5 clear empties cache");

        // R8: trace_start during a stalled forward
        hold_out = 1;
        send(16'd100, 4'h9);
        @(negedge clk);
        @(negedge clk);
        trace_start = 1;
        @(negedge clk);
        trace_start = 0;
        m_clear();
        chk(out_valid == 1, "R8 out_valid held", out_valid, 1);
        chk(out_obj == 16'd100, "R8 out_obj held", out_obj, 100);
        chk(out_lanes == 4'h9, "R8 out_lanes held", out_lanes, 9);
        hold_out = 0;
        drain();
        send(16'd100, 4'h1);     // cleared, so a miss
        drain();
        check_counts("R8");

        // random stalls on a small identifier pool
        stall_mode = 1;
        for (int k = 0; k < 300; k++) begin
            if (k % 60 == 59) begin
                drain();
                start_trace(16'(k));
            end
            send(16'((k * 7 + k / 5) % 9), 4'(k % 16));
        end
        drain();
        stall_mode = 0;
        chk(exp_q.size() == 0, "R2 scoreboard empty", exp_q.size(), 0);
        check_counts("R7 final");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule